// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches up to 32 general-purpose input pins of one bank and turns selected pin activity into pending interrupt flags. Each pin has its own trigger choice: it can fire on a high level, a low level, a rising edge or a falling edge. A pin can only raise its flag while its bit in the source-enable register is 1. Pending flags are held in a status register until software removes them.

Software reaches the block through a simple word-addressed register bus. The status register can be read at its base address. It can also be written through three alias addresses that set, clear or invert only the bits written as 1. A separate mask register selects which pending flags drive the single active-high bank interrupt output. For a level-triggered pin, a clear takes effect only when the pin is no longer at its active level or its source enable has been removed. While the condition persists, the flag re-asserts.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every configuration register, the status register and `irq_o` are 0.
- R2: Register groups are selected by address bits [7:4] with bits [1:0] zero: status at 0x00, source enable at 0x10, trigger mode at 0x20 (bit 1 = level, 0 = edge), polarity at 0x30 (bit 1 = high/rising, 0 = low/falling), interrupt mask at 0x40. The configuration registers read back what was written. Reads at 0x00, 0x04, 0x08 and 0x0C all return the status value.
- R3: A pin transition that meets its trigger becomes visible in the status register on the third rising clock edge after the pin changes, and not earlier.
- R4: Each of the four triggers sets the pin's status bit: level high, level low, rising edge and falling edge. An edge of the opposite direction does not set it.
- R5: A pin whose source-enable bit is 0 never sets its status bit, whatever its activity or trigger mode.
- R6: A write to 0x08 clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R7: A write to 0x04 sets each status bit written as 1. A write to 0x0C inverts each status bit written as 1.
- R8: A clear of a level-triggered bit has no effect while its pin is at the active level and still enabled. The clear succeeds once the pin is inactive or its enable bit is 0.
- R9: When a hardware trigger and a software clear hit the same bit in the same cycle, the bit ends up 1.
- R10: `irq_o` is 1 exactly one cycle after any status bit and its mask bit are both 1, and 0 one cycle after no such pair exists.
- R11: An edge-triggered status bit stays 1 after the pin activity ends, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_PINS | Raw pin levels, asynchronous to clk_i |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Bank interrupt, active high |

## Verification
The assertions assume that a write strobe lasts one clock and that the address is stable while it is high. They also assume that pins which change while enabled are meant to be seen as events, so every bit that rises without a write must trace back to an enabled pin. The stimulus drives the bus and the pins only at falling clock edges. It rewrites the trigger configuration only while the source-enable register is 0, so a change of mode never creates an event. It also holds each pin level for at least three clocks, so every transition passes the synchronizer.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int BUS_W = 32;

  // register group index taken from address bits above the alias field
  localparam int GRP_STATUS = 0;
  localparam int GRP_SRC_EN = 1;
  localparam int GRP_MODE   = 2;
  localparam int GRP_POL    = 3;
  localparam int GRP_MASK   = 4;

  typedef enum logic [1:0] {
    ALIAS_RAW = 2'd0,
    ALIAS_SET = 2'd1,
    ALIAS_CLR = 2'd2,
    ALIAS_TOG = 2'd3
  } alias_e;

  // one pin: does the trigger condition hold this cycle?
  function automatic logic f_trigger(input logic is_level, input logic act_high,
                                     input logic cur, input logic prev);
    logic at_level;
    at_level = act_high ? cur : ~cur;
    if (is_level) return at_level;
    return at_level && (cur != prev);
  endfunction

  // software view of a status write through one alias
  function automatic logic [BUS_W-1:0] f_alias_write(input logic [BUS_W-1:0] cur,
                                                     input alias_e sel,
                                                     input logic [BUS_W-1:0] wd);
    unique case (sel)
      ALIAS_RAW: return wd;
      ALIAS_SET: return cur | wd;
      ALIAS_CLR: return cur & ~wd;
      default:   return cur ^ wd;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int N_PINS = 32,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_sync_o
);

  logic [N_PINS-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pin_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_sync_i,
  input  logic [N_PINS-1:0] mode_level_i,
  input  logic [N_PINS-1:0] pol_high_i,
  output logic [N_PINS-1:0] hit_o,
  output logic [N_PINS-1:0] level_active_o
);
  import gpio_irq_pkg::*;

  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= pin_sync_i;
  end

  generate
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      assign hit_o[p] = f_trigger(mode_level_i[p], pol_high_i[p],
                                  pin_sync_i[p], prev_q[p]);
      assign level_active_o[p] = mode_level_i[p] &&
                                 (pol_high_i[p] ? pin_sync_i[p] : ~pin_sync_i[p]);
    end
  endgenerate

  // an edge hit needs the pin to have moved since the last cycle
  assert_edge_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_o & ~mode_level_i & ~(pin_sync_i ^ prev_q)) == '0));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               bus_addr_i,
  input  logic                            bus_we_i,
  input  logic [gpio_irq_pkg::BUS_W-1:0]  bus_wdata_i,
  output logic [gpio_irq_pkg::BUS_W-1:0]  bus_rdata_o,
  input  logic [N_PINS-1:0]               hit_i,
  input  logic [N_PINS-1:0]               level_active_i,
  output logic [N_PINS-1:0]               src_en_o,
  output logic [N_PINS-1:0]               mode_level_o,
  output logic [N_PINS-1:0]               pol_high_o,
  output logic [N_PINS-1:0]               mask_o,
  output logic [N_PINS-1:0]               status_o
);
  import gpio_irq_pkg::*;

  localparam int GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0] grp;
  alias_e           sel;
  logic             aligned;
  logic             wr_status, wr_en, wr_mode, wr_pol, wr_mask;

  logic [N_PINS-1:0] src_en_q, mode_q, pol_q, mask_q, status_q, status_d;
  logic [BUS_W-1:0]  status_ext, sw_view;

  // named internal events for the checks
  logic [N_PINS-1:0] hw_set;
  logic [N_PINS-1:0] clr_req;
  logic [N_PINS-1:0] clear_blocked;

  assign grp     = bus_addr_i[ADDR_W-1:4];
  assign sel     = alias_e'(bus_addr_i[3:2]);
  assign aligned = (bus_addr_i[1:0] == 2'b00);

  assign wr_status = bus_we_i && aligned && (grp == GRP_W'(GRP_STATUS));
  assign wr_en     = bus_we_i && aligned && (grp == GRP_W'(GRP_SRC_EN)) && (sel == ALIAS_RAW);
  assign wr_mode   = bus_we_i && aligned && (grp == GRP_W'(GRP_MODE))   && (sel == ALIAS_RAW);
  assign wr_pol    = bus_we_i && aligned && (grp == GRP_W'(GRP_POL))    && (sel == ALIAS_RAW);
  assign wr_mask   = bus_we_i && aligned && (grp == GRP_W'(GRP_MASK))   && (sel == ALIAS_RAW);

  assign hw_set        = hit_i & src_en_q;
  assign clr_req       = (wr_status && sel == ALIAS_CLR) ? bus_wdata_i[N_PINS-1:0] : '0;
  assign clear_blocked = clr_req & level_active_i & src_en_q;

  always_comb begin
    status_ext = '0;
    status_ext[N_PINS-1:0] = status_q;
    sw_view = wr_status ? f_alias_write(status_ext, sel, bus_wdata_i) : status_ext;
    // a hardware set takes priority over any software change this cycle
    status_d = sw_view[N_PINS-1:0] | hw_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_en_q <= '0;
      mode_q   <= '0;
      pol_q    <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_en)   src_en_q <= bus_wdata_i[N_PINS-1:0];
      if (wr_mode) mode_q   <= bus_wdata_i[N_PINS-1:0];
      if (wr_pol)  pol_q    <= bus_wdata_i[N_PINS-1:0];
      if (wr_mask) mask_q   <= bus_wdata_i[N_PINS-1:0];
      status_q <= status_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (aligned) begin
      if (grp == GRP_W'(GRP_STATUS))                           bus_rdata_o[N_PINS-1:0] = status_q;
      else if (grp == GRP_W'(GRP_SRC_EN) && sel == ALIAS_RAW)  bus_rdata_o[N_PINS-1:0] = src_en_q;
      else if (grp == GRP_W'(GRP_MODE)   && sel == ALIAS_RAW)  bus_rdata_o[N_PINS-1:0] = mode_q;
      else if (grp == GRP_W'(GRP_POL)    && sel == ALIAS_RAW)  bus_rdata_o[N_PINS-1:0] = pol_q;
      else if (grp == GRP_W'(GRP_MASK)   && sel == ALIAS_RAW)  bus_rdata_o[N_PINS-1:0] = mask_q;
    end
  end

  assign src_en_o     = src_en_q;
  assign mode_level_o = mode_q;
  assign pol_high_o   = pol_q;
  assign mask_o       = mask_q;
  assign status_o     = status_q;

  assert_hw_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set != '0) |=> ((status_q & $past(hw_set)) == $past(hw_set)));

  assert_no_set_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_status) |=> ((status_q & ~$past(status_q) & ~$past(src_en_q)) == '0));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_req & ~hit_i) != '0) |=> ((status_q & $past(clr_req & ~hit_i)) == '0));

  assert_level_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_blocked != '0) |=> ((status_q & $past(clear_blocked)) == $past(clear_blocked)));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PINS-1:0]              pin_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic                           bus_we_i,
  input  logic [gpio_irq_pkg::BUS_W-1:0] bus_wdata_i,
  output logic [gpio_irq_pkg::BUS_W-1:0] bus_rdata_o,
  output logic                           irq_o
);

  logic [N_PINS-1:0] pin_sync, hit, level_active;
  logic [N_PINS-1:0] src_en, mode_level, pol_high, mask, status;
  logic              irq_q;

  gpio_irq_sync #(.N_PINS(N_PINS), .STAGES(2)) sync_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .pin_sync_o (pin_sync)
  );

  gpio_irq_detect #(.N_PINS(N_PINS)) detect_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pin_sync_i     (pin_sync),
    .mode_level_i   (mode_level),
    .pol_high_i     (pol_high),
    .hit_o          (hit),
    .level_active_o (level_active)
  );

  gpio_irq_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) regs_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bus_addr_i     (bus_addr_i),
    .bus_we_i       (bus_we_i),
    .bus_wdata_i    (bus_wdata_i),
    .bus_rdata_o    (bus_rdata_o),
    .hit_i          (hit),
    .level_active_i (level_active),
    .src_en_o       (src_en),
    .mode_level_o   (mode_level),
    .pol_high_o     (pol_high),
    .mask_o         (mask),
    .status_o       (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= |(status & mask);
  end

  assign irq_o = irq_q;

  assert_irq_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status & mask))));

  assert_src_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit & src_en & ~status) != '0) |=> (status != '0));

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  localparam logic [7:0] A_STAT = 8'h00, A_SET = 8'h04, A_CLR = 8'h08, A_TOG = 8'h0C;
  localparam logic [7:0] A_EN = 8'h10, A_MODE = 8'h20, A_POL = 8'h30, A_MASK = 8'h40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.N_PINS(NP), .ADDR_W(8)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pins),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [31:0] en, input logic [31:0] md,
                     input logic [31:0] pl, input logic [31:0] mk);
    wr(A_EN, 32'h0);
    wr(A_MODE, md);
    wr(A_POL, pl);
    wr(A_MASK, mk);
    wr(A_EN, en);
  endtask

  task automatic quiesce();
    wr(A_EN, 32'h0);
    @(negedge clk) pins = '0;
    cycles(4);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_STAT, v); check("R1 status", v, 32'h0);
    rd(A_EN, v);   check("R1 enable", v, 32'h0);
    rd(A_MODE, v); check("R1 mode", v, 32'h0);
    rd(A_POL, v);  check("R1 polarity", v, 32'h0);
    rd(A_MASK, v); check("R1 mask", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_MODE, 32'h1234_5678); rd(A_MODE, v); check("R2 mode readback", v, 32'h1234_5678);
    wr(A_POL, 32'hCAFE_0001);  rd(A_POL, v);  check("R2 pol readback", v, 32'hCAFE_0001);
    wr(A_MASK, 32'h0F0F_F0F0); rd(A_MASK, v); check("R2 mask readback", v, 32'h0F0F_F0F0);
    wr(A_MODE, 32'h0); wr(A_POL, 32'h0); wr(A_MASK, 32'h0);
    wr(A_SET, 32'h8000_0003);
    rd(A_STAT, v); check("R7 set alias", v, 32'h8000_0003);
    rd(A_SET, v);  check("R2 read at set alias", v, 32'h8000_0003);
    rd(A_CLR, v);  check("R2 read at clear alias", v, 32'h8000_0003);
    rd(A_TOG, v);  check("R2 read at toggle alias", v, 32'h8000_0003);
    wr(A_TOG, 32'h0000_0005);
    rd(A_STAT, v); check("R7 toggle alias", v, 32'h8000_0006);
    wr(A_CLR, 32'h0000_0002);
    rd(A_STAT, v); check("R6 clear ones", v, 32'h8000_0004);
    wr(A_CLR, 32'h0);
    rd(A_STAT, v); check("R6 zeros unchanged", v, 32'h8000_0004);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R6 clear all", v, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    cfg(32'h1, 32'h0, 32'h1, 32'h0);
    @(negedge clk) pins[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd(A_STAT, v); check("R3 not before third edge", v, 32'h0);
    @(posedge clk);
    rd(A_STAT, v); check("R3 on third edge (R4 rising)", v, 32'h1);
    quiesce();
  endtask

  task automatic t_triggers();
    logic [31:0] v;
    cfg(32'h2, 32'h0, 32'h0, 32'h0);
    @(negedge clk) pins[1] = 1'b1;
    cycles(4);
    rd(A_STAT, v); check("R4 rise ignored on falling pin", v, 32'h0);
    @(negedge clk) pins[1] = 1'b0;
    cycles(4);
    rd(A_STAT, v); check("R4 falling edge", v, 32'h2);
    cycles(6);
    rd(A_STAT, v); check("R11 edge bit held", v, 32'h2);
    quiesce();
    cfg(32'h4, 32'h4, 32'h4, 32'h0);
    cycles(3);
    rd(A_STAT, v); check("R4 level high idle", v, 32'h0);
    @(negedge clk) pins[2] = 1'b1;
    cycles(4);
    rd(A_STAT, v); check("R4 level high", v, 32'h4);
    quiesce();
    cfg(32'h8, 32'h8, 32'h0, 32'h0);
    cycles(3);
    rd(A_STAT, v); check("R4 level low", v, 32'h8);
    quiesce();
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    cfg(32'h0, 32'h40, 32'h50, 32'h0);
    @(negedge clk) begin pins[4] = 1'b1; pins[6] = 1'b1; end
    cycles(4);
    @(negedge clk) pins[4] = 1'b0;
    cycles(4);
    rd(A_STAT, v); check("R5 disabled pins never set", v, 32'h0);
    quiesce();
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    cfg(32'h4, 32'h4, 32'h4, 32'h0);
    @(negedge clk) pins[2] = 1'b1;
    cycles(4);
    wr(A_CLR, 32'h4);
    rd(A_STAT, v); check("R8 clear blocked while active", v, 32'h4);
    @(negedge clk) pins[2] = 1'b0;
    cycles(3);
    wr(A_CLR, 32'h4);
    rd(A_STAT, v); check("R8 clear after pin inactive", v, 32'h0);
    @(negedge clk) pins[2] = 1'b1;
    cycles(4);
    rd(A_STAT, v); check("R8 level re-asserts", v, 32'h4);
    wr(A_EN, 32'h0);
    wr(A_CLR, 32'h4);
    rd(A_STAT, v); check("R8 clear after disable", v, 32'h0);
    quiesce();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    cfg(32'h20, 32'h0, 32'h20, 32'h0);
    @(negedge clk) pins[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(A_CLR, 32'h20);
    rd(A_STAT, v); check("R9 hardware set wins", v, 32'h20);
    wr(A_CLR, 32'h20);
    rd(A_STAT, v); check("R9 later clear works (R11)", v, 32'h0);
    quiesce();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    cfg(32'h0, 32'h0, 32'h0, 32'h1);
    wr(A_SET, 32'h1);
    check("R10 irq one cycle late", {31'h0, irq}, 32'h0);
    cycles(1);
    check("R10 irq asserted", {31'h0, irq}, 32'h1);
    wr(A_MASK, 32'h2);
    cycles(1);
    check("R10 masked bit gives no irq", {31'h0, irq}, 32'h0);
    wr(A_SET, 32'h2);
    cycles(1);
    check("R10 second bit raises irq", {31'h0, irq}, 32'h1);
    wr(A_CLR, 32'h3);
    check("R10 irq held one cycle after clear", {31'h0, irq}, 32'h1);
    cycles(1);
    check("R10 irq drops", {31'h0, irq}, 32'h0);
    rd(A_STAT, v); check("R6 status empty", v, 32'h0);
    wr(A_MASK, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_regmap();
    t_latency();
    t_triggers();
    t_disabled();
    t_sticky();
    t_collide();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule